// File: doc/BRIEF.md
# Interrupt Source Capture and Enable Bank

This block is the input stage of an interrupt controller. It takes a vector of asynchronous system interrupt lines, brings each one into the local clock domain, and detects an event on it according to a per-source sense setting. A source can be sensitive to a high level, a low level, a rising edge or a falling edge. A detected event sets a sticky raw status bit. A separate enable bit per source decides whether that status reaches the pending output, which the priority and routing logic downstream consumes.

Software reaches the bank through a single write port. Sense settings are held as 32-bit words, one bit per source. Status and enable bits can be changed in two ways. Bulk registers take a bit mask. Indexed registers take a source number, so one source can be changed with a single write and no read-modify-write. The register map is fixed: sense-select words at 0x00+w, edge/level words at 0x08+w, bulk status clear at 0x10+w, bulk enable clear at 0x18+w, indexed status clear at 0x20, indexed enable set at 0x21 and indexed enable clear at 0x22. Word w covers sources 32w to 32w+31. Source s lives in bit s mod 32 of word s/32.

Top module: `isc_capture_bank`

## Requirements
- R1: After reset, raw status, enable and pending are all zero. Every sense-select bit and edge/level bit is 0. Event detection stays suppressed until three clock edges after reset release.
- R2: A source with sense bit 1 and edge/level bit 1 sets its status on a rising input. The status stays set after the input falls again, until a clear is written.
- R3: A source with sense bit 0 and edge/level bit 1 sets its status on a falling input.
- R4: A source with sense bit 1 and edge/level bit 0 sets its status while its input is high. A clear written while the input is still high has no effect.
- R5: A source with sense bit 0 and edge/level bit 0 sets its status while its input is low. A clear written while the input is still low has no effect.
- R6: Writing a source number to the indexed status clear (0x20, number in data bits 9:0) clears only that source's status bit.
- R7: A write to the bulk status clear (0x10+w) clears each status bit whose data bit is 1. Data bits that are 0 leave their status unchanged.
- R8: Writing a source number to the indexed enable set (0x21) sets that source's enable bit. Writing it to the indexed enable clear (0x22) clears it. Other enable bits are unchanged.
- R9: A write to the bulk enable clear (0x18+w) clears each enable bit whose data bit is 1.
- R10: The pending output is, bit for bit, raw status AND enable. It follows register changes with no extra cycle.
- R11: If an event is detected on a source in the same cycle as a clear of that source's status, the status ends up set.
- R12: An indexed write whose 10-bit number is not below NUM_SRC changes no status or enable bit.
- R13: A change on an input line reaches the raw status at the third rising clock edge after the change: two synchronizer stages, then the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Asynchronous interrupt lines, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register word address |
| wr_data | input | 32 | Write data: a mask, a sense word or a source number |
| raw_status | output | NUM_SRC | Sticky detected-event bits |
| enable_mask | output | NUM_SRC | Per-source enable bits |
| pending | output | NUM_SRC | Status gated by enable |

## Verification
Two functions can meet in one cycle. The first is detection of a new edge on a source. The second is a software clear of that same source's status. The bench drives a falling input, waits exactly two clock edges so that the synchronized edge is present at the third edge, and issues the indexed status clear on that third edge. The status must read as set afterwards, and a second clear one cycle later must then take effect. The reference model also runs a long random mix of input toggles and writes, and compares status, enable and pending every cycle. This mix hits the same collision many more times, along with level sources being cleared while they are still active.

// File: rtl/isc_pkg.sv
// Package: isc_pkg
// Shared constants and types for the interrupt source capture bank.
// Assumes a single 32-bit write data path and a 6-bit word address.
package isc_pkg;

    localparam int REG_ADDR_W  = 6;
    localparam int DATA_W      = 32;
    localparam int IDX_FIELD_W = 10;
    localparam int MAX_WORDS   = 8;

    localparam logic [REG_ADDR_W-1:0] A_SENSE_BASE = 6'h00;
    localparam logic [REG_ADDR_W-1:0] A_KIND_BASE  = 6'h08;
    localparam logic [REG_ADDR_W-1:0] A_SCLR_BASE  = 6'h10;
    localparam logic [REG_ADDR_W-1:0] A_ECLR_BASE  = 6'h18;
    localparam logic [REG_ADDR_W-1:0] A_SCLR_IDX   = 6'h20;
    localparam logic [REG_ADDR_W-1:0] A_ESET_IDX   = 6'h21;
    localparam logic [REG_ADDR_W-1:0] A_ECLR_IDX   = 6'h22;

    // Detection mode, encoded as {edge/level bit, sense bit}
    typedef enum logic [1:0] {
        SENSE_LVL_LOW   = 2'b00,
        SENSE_LVL_HIGH  = 2'b01,
        SENSE_EDGE_FALL = 2'b10,
        SENSE_EDGE_RISE = 2'b11
    } sense_t;

endpackage

// File: rtl/isc_sync_detect.sv
// Module: isc_sync_detect
// Brings every interrupt line through a SYNC_STAGES flop chain and detects
// the configured event per source. Detection is held off until the chain
// and the previous-sample flop hold post-reset data.
// Assumes sense/kind inputs are stable register outputs.
module isc_sync_detect
    import isc_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] sense,
    input  logic [NUM_SRC-1:0] kind,
    output logic [NUM_SRC-1:0] hit
);

    localparam int PRIME = SYNC_STAGES + 1;
    localparam int CNT_W = $clog2(PRIME + 1);

    logic [NUM_SRC-1:0] stg [SYNC_STAGES];
    logic [NUM_SRC-1:0] prev_q;
    logic [CNT_W-1:0]   prime_cnt;
    logic               primed;

    // Synchronizer chain plus one previous-sample stage for edge compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= '0;
            prev_q <= '0;
        end else begin
            stg[0] <= irq_in;
            for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
            prev_q <= stg[SYNC_STAGES-1];
        end
    end

    // Count edges after reset until the sample pipeline is fully valid
    always_ff @(posedge clk) begin
        if (!rst_n)                          prime_cnt <= '0;
        else if (prime_cnt != CNT_W'(PRIME)) prime_cnt <= prime_cnt + 1'b1;
    end

    assign primed = (prime_cnt == CNT_W'(PRIME));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        sense_t mode;
        logic   now_b;
        logic   old_b;
        logic   det;

        assign mode  = sense_t'({kind[i], sense[i]});
        assign now_b = stg[SYNC_STAGES-1][i];
        assign old_b = prev_q[i];

        // Per-source event decision for the selected mode
        always_comb begin
            unique case (mode)
                SENSE_LVL_LOW:   det = ~now_b;
                SENSE_LVL_HIGH:  det = now_b;
                SENSE_EDGE_FALL: det = ~now_b & old_b;
                default:         det = now_b & ~old_b;
            endcase
        end

        assign hit[i] = primed & det;
    end

endmodule

// File: rtl/isc_reg_decode.sv
// Module: isc_reg_decode
// Decodes the write port. Holds the sense and edge/level words and turns
// bulk and indexed writes into one-cycle set/clear masks.
// Assumes at most one write per cycle and NUM_SRC <= 32*MAX_WORDS.
module isc_reg_decode
    import isc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [NUM_SRC-1:0]    sense,
    output logic [NUM_SRC-1:0]    kind,
    output logic [NUM_SRC-1:0]    sclr_mask,
    output logic [NUM_SRC-1:0]    eclr_mask,
    output logic [NUM_SRC-1:0]    eset_mask
);

    localparam int WORDS = (NUM_SRC + DATA_W - 1) / DATA_W;
    localparam int PAD   = WORDS * DATA_W;

    logic [PAD-1:0]         sense_q;
    logic [PAD-1:0]         kind_q;
    logic [PAD-1:0]         sclr_bulk;
    logic [PAD-1:0]         eclr_bulk;
    logic [NUM_SRC-1:0]     idx_oh;
    logic [IDX_FIELD_W-1:0] idx;

    // Word-wide sense and edge/level registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            kind_q  <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < WORDS; w++) begin
                if (wr_addr == A_SENSE_BASE + REG_ADDR_W'(w))
                    sense_q[w*DATA_W +: DATA_W] <= wr_data;
                if (wr_addr == A_KIND_BASE + REG_ADDR_W'(w))
                    kind_q[w*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

    // Bulk clear masks from the addressed word
    always_comb begin
        sclr_bulk = '0;
        eclr_bulk = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (wr_en && wr_addr == A_SCLR_BASE + REG_ADDR_W'(w))
                sclr_bulk[w*DATA_W +: DATA_W] = wr_data;
            if (wr_en && wr_addr == A_ECLR_BASE + REG_ADDR_W'(w))
                eclr_bulk[w*DATA_W +: DATA_W] = wr_data;
        end
    end

    assign idx = wr_data[IDX_FIELD_W-1:0];

    // Full-width compare so numbers at or above NUM_SRC select nothing
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_oh
        assign idx_oh[i] = (idx == IDX_FIELD_W'(i));
    end

    assign sense     = sense_q[NUM_SRC-1:0];
    assign kind      = kind_q[NUM_SRC-1:0];
    assign sclr_mask = sclr_bulk[NUM_SRC-1:0]
                     | ((wr_en && wr_addr == A_SCLR_IDX) ? idx_oh : '0);
    assign eclr_mask = eclr_bulk[NUM_SRC-1:0]
                     | ((wr_en && wr_addr == A_ECLR_IDX) ? idx_oh : '0);
    assign eset_mask = (wr_en && wr_addr == A_ESET_IDX) ? idx_oh : '0;

endmodule

// File: rtl/isc_status_bank.sv
// Module: isc_status_bank
// Sticky raw status and enable registers. A detected event outranks a
// clear of the same bit. An enable set outranks an enable clear.
// Assumes the masks are single-cycle pulses from the decoder.
module isc_status_bank #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hit,
    input  logic [NUM_SRC-1:0] sclr_mask,
    input  logic [NUM_SRC-1:0] eclr_mask,
    input  logic [NUM_SRC-1:0] eset_mask,
    output logic [NUM_SRC-1:0] status_q,
    output logic [NUM_SRC-1:0] enable_q
);

    // Status: clear first, then new events on top
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~sclr_mask) | hit;
    end

    // Enable: clear first, then indexed set
    always_ff @(posedge clk) begin
        if (!rst_n) enable_q <= '0;
        else        enable_q <= (enable_q & ~eclr_mask) | eset_mask;
    end

endmodule

// File: rtl/isc_capture_bank.sv
// Module: isc_capture_bank
// Top of the interrupt source capture bank: synchronizer/detector,
// register decoder and status/enable bank. Pending is status AND enable.
// Assumes irq_in is asynchronous and writes arrive one per cycle.
module isc_capture_bank
    import isc_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    irq_in,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [NUM_SRC-1:0]    raw_status,
    output logic [NUM_SRC-1:0]    enable_mask,
    output logic [NUM_SRC-1:0]    pending
);

    logic [NUM_SRC-1:0] sense;
    logic [NUM_SRC-1:0] kind;
    logic [NUM_SRC-1:0] hit;
    logic [NUM_SRC-1:0] sclr_mask;
    logic [NUM_SRC-1:0] eclr_mask;
    logic [NUM_SRC-1:0] eset_mask;

    isc_sync_detect #(
        .NUM_SRC     (NUM_SRC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .sense  (sense),
        .kind   (kind),
        .hit    (hit)
    );

    isc_reg_decode #(
        .NUM_SRC (NUM_SRC)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sense     (sense),
        .kind      (kind),
        .sclr_mask (sclr_mask),
        .eclr_mask (eclr_mask),
        .eset_mask (eset_mask)
    );

    isc_status_bank #(
        .NUM_SRC (NUM_SRC)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .sclr_mask (sclr_mask),
        .eclr_mask (eclr_mask),
        .eset_mask (eset_mask),
        .status_q  (raw_status),
        .enable_q  (enable_mask)
    );

    // Gate raw status with enable for the downstream consumer
    assign pending = raw_status & enable_mask;

endmodule

// File: rtl/isc_capture_bank_chk.sv
// Module: isc_capture_bank_chk
// Port-level temporal checks for isc_capture_bank, attached with bind.
// Assumes the default register map from isc_pkg.
module isc_capture_bank_chk
    import isc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [REG_ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0]     wr_data,
    input logic [NUM_SRC-1:0]    raw_status,
    input logic [NUM_SRC-1:0]    enable_mask
);

    localparam int LOW_W = (NUM_SRC < DATA_W) ? NUM_SRC : DATA_W;

    logic [NUM_SRC-1:0] chk_oh;
    logic               sclr_any;
    logic               idx_out_of_range;

    // Independent one-hot of the written source number
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
            chk_oh[i] = (wr_data[IDX_FIELD_W-1:0] == IDX_FIELD_W'(i));
    end

    assign sclr_any = wr_en && (wr_addr == A_SCLR_IDX ||
                      (wr_addr >= A_SCLR_BASE &&
                       wr_addr <  A_SCLR_BASE + REG_ADDR_W'(MAX_WORDS)));
    assign idx_out_of_range = (32'(wr_data[IDX_FIELD_W-1:0]) >= NUM_SRC);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (raw_status == '0 && enable_mask == '0));

    assert_status_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sclr_any |=> ((raw_status & $past(raw_status)) == $past(raw_status)));

    assert_idx_clear_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_SCLR_IDX)
        |=> (($past(raw_status) & ~$past(chk_oh) & ~raw_status) == '0));

    assert_idx_enable_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_ESET_IDX)
        |=> ((enable_mask & $past(chk_oh)) == $past(chk_oh)));

    assert_bulk_enable_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_ECLR_BASE)
        |=> ((enable_mask[LOW_W-1:0] & $past(wr_data[LOW_W-1:0])) == '0));

    assert_bad_index_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx_out_of_range &&
         (wr_addr == A_ESET_IDX || wr_addr == A_ECLR_IDX))
        |=> $stable(enable_mask));

endmodule

bind isc_capture_bank isc_capture_bank_chk #(
    .NUM_SRC (NUM_SRC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .raw_status  (raw_status),
    .enable_mask (enable_mask)
);

// File: tb/isc_capture_bank_tb.sv
`timescale 1ns/1ps
module isc_capture_bank_tb;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_v = '1;
    logic         wr_en = 1'b0;
    logic [5:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [N-1:0] raw_status, enable_mask, pending;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state
    logic [N-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
    logic [N-1:0] m_pol = '0, m_typ = '0, m_stat = '0, m_en = '0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    isc_capture_bank u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in      (irq_v),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .raw_status  (raw_status),
        .enable_mask (enable_mask),
        .pending     (pending)
    );

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance the model by one clock edge, from the requirements
    task automatic model_step();
        logic [N-1:0] hit, sclr, eclr, eset;
        logic aq, ap;
        int idx;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_pol = '0; m_typ = '0;
            m_stat = '0; m_en = '0; m_cnt = 0;
            return;
        end
        hit = '0; sclr = '0; eclr = '0; eset = '0;
        if (m_cnt == 3) begin
            for (int i = 0; i < N; i++) begin
                aq = (m_s2[i] == m_pol[i]);
                ap = (m_prev[i] == m_pol[i]);
                hit[i] = m_typ[i] ? (aq && !ap) : aq;
            end
        end
        idx = int'(wr_data[9:0]);
        if (wr_en) begin
            case (wr_addr)
                6'h10: sclr = wr_data;
                6'h18: eclr = wr_data;
                6'h20: if (idx < N) sclr[idx] = 1'b1;
                6'h21: if (idx < N) eset[idx] = 1'b1;
                6'h22: if (idx < N) eclr[idx] = 1'b1;
                default: ;
            endcase
        end
        m_stat = (m_stat & ~sclr) | hit;
        m_en   = (m_en & ~eclr) | eset;
        if (wr_en && wr_addr == 6'h00) m_pol = wr_data;
        if (wr_en && wr_addr == 6'h08) m_typ = wr_data;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = irq_v;
        if (m_cnt < 3) m_cnt++;
    endtask

    // One clock: model at the edge, compare at the following falling edge
    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R2 status vs model", raw_status, m_stat);
        chk("R8 enable vs model", enable_mask, m_en);
        chk("R10 pending vs model", pending, m_stat & m_en);
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cycle();
        wr_en = 1'b0;
    endtask

    task automatic wait_n(int n);
        for (int k = 0; k < n; k++) cycle();
    endtask

    initial begin
        logic [N-1:0] snap;
        void'($urandom(32'h5eed_1c0d));
        wait_n(3);
        rst_n = 1'b1;
        cycle();
        chk("R1 status after reset", raw_status, '0);
        chk("R1 enable after reset", enable_mask, '0);
        wait_n(4);
        chk("R1 pending idle", pending, '0);

        // R13/R5: active-low level on sources 0 and 1, latency of three edges
        irq_v[0] = 1'b0; irq_v[1] = 1'b0;
        wait_n(2);
        chk("R13 not yet visible", raw_status & 32'h3, '0);
        cycle();
        chk("R13 visible at third edge", raw_status & 32'h3, 32'h3);
        wr(6'h20, 32'd0);
        chk("R5 clear ignored while low", raw_status & 32'h3, 32'h3);
        irq_v[0] = 1'b1; irq_v[1] = 1'b1;
        wait_n(3);
        wr(6'h20, 32'd0);
        chk("R6 indexed clear only source 0", raw_status & 32'h3, 32'h2);
        wr(6'h10, 32'h0);
        chk("R7 zero mask no effect", raw_status & 32'h3, 32'h2);
        wr(6'h10, 32'h2);
        chk("R7 bulk clear", raw_status & 32'h3, 32'h0);

        // R4: active-high level on source 4
        wr(6'h00, 32'h10);
        cycle();
        chk("R4 high level sets", raw_status & 32'h10, 32'h10);
        wr(6'h10, 32'h10);
        chk("R4 clear ignored while high", raw_status & 32'h10, 32'h10);
        irq_v[4] = 1'b0;
        wait_n(3);
        wr(6'h10, 32'h10);
        chk("R4 clear after release", raw_status & 32'h10, 32'h0);

        // R2: rising edge on source 8 (kind first, then sense)
        wr(6'h08, 32'h100);
        wr(6'h00, 32'h110);
        wait_n(2);
        chk("R2 no event on config", raw_status & 32'h100, 32'h0);
        irq_v[8] = 1'b0;
        wait_n(4);
        chk("R2 fall ignored", raw_status & 32'h100, 32'h0);
        irq_v[8] = 1'b1;
        wait_n(3);
        chk("R2 rising sets", raw_status & 32'h100, 32'h100);
        irq_v[8] = 1'b0;
        wait_n(4);
        chk("R2 sticky", raw_status & 32'h100, 32'h100);
        wr(6'h10, 32'h100);

        // R3: falling edge on source 9
        wr(6'h08, 32'h300);
        irq_v[9] = 1'b0;
        wait_n(3);
        chk("R3 falling sets", raw_status & 32'h200, 32'h200);

        // R8/R10: indexed enable
        wr(6'h21, 32'd9);
        chk("R8 enable set", enable_mask, 32'h200);
        chk("R10 pending follows", pending, 32'h200);
        wr(6'h21, 32'd2);
        chk("R10 enabled but no status", pending, 32'h200);
        wr(6'h22, 32'd9);
        chk("R8 enable clear", enable_mask, 32'h4);
        chk("R10 pending gated", pending, 32'h0);

        // R12: out-of-range numbers
        snap = enable_mask;
        wr(6'h21, 32'd41);
        chk("R12 set index 41 ignored", enable_mask, snap);
        wr(6'h22, 32'h3FF);
        chk("R12 clear index 1023 ignored", enable_mask, snap);

        // R9: bulk enable clear
        wr(6'h21, 32'd3); wr(6'h21, 32'd4); wr(6'h21, 32'd5);
        wr(6'h18, 32'h28);
        chk("R9 bulk enable clear", enable_mask, 32'h14);

        // R11: edge and clear in the same cycle on source 9
        irq_v[9] = 1'b1;
        wait_n(3);
        wr(6'h20, 32'd9);
        chk("R11 baseline clear", raw_status & 32'h200, 32'h0);
        irq_v[9] = 1'b0;
        wait_n(2);
        wr(6'h20, 32'd9);
        chk("R11 set wins over clear", raw_status & 32'h200, 32'h200);
        wr(6'h20, 32'd9);
        chk("R11 later clear works", raw_status & 32'h200, 32'h0);

        // Random mix against the model
        for (int n = 0; n < 4000; n++) begin
            logic [5:0] addrs [8] = '{6'h00, 6'h08, 6'h10, 6'h18,
                                      6'h20, 6'h21, 6'h22, 6'h30};
            logic [5:0] a;
            irq_v = irq_v ^ ($urandom & $urandom & $urandom);
            if (($urandom % 3) == 0) begin
                a = addrs[$urandom % 8];
                if (a >= 6'h20 && a <= 6'h22) wr(a, $urandom % 40);
                else if (a == 6'h10 || a == 6'h18)
                    wr(a, $urandom & $urandom & $urandom);
                else wr(a, $urandom);
            end else begin
                cycle();
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule